// File: doc/BRIEF.md
# Selectable-Mode Fixed-Point Rounding Stage

This block narrows a signed two's-complement sample from `IN_W` bits to `OUT_W` bits. It keeps the upper `OUT_W` bits of the input and may add one to them, according to a rounding policy fixed at elaboration. There are four policies: plain truncation, round-half-up, round-half-away-from-zero and convergent round-half-to-even. The convergent policy is the one to use when many stages are cascaded, because it does not build up a bias. The block is meant to sit at the output of each stage of a pipelined FFT.

The result is registered once. A sync/valid flag travels beside the sample through a matching register, so the flag stays aligned with the rounded word. A clock enable stalls both registers. A synchronous reset clears the word and the flag. When the rounded value does not fit in `OUT_W` bits, it wraps modulo 2^`OUT_W`; the block does not saturate.

Top module: `fxp_round_stage`

## Requirements
- R1: With `MODE = RND_TRUNC` (code 0), the output word equals input bits [`IN_W-1`:`IN_W-OUT_W`] unchanged.
- R2: With `MODE = RND_HALF_UP` (code 1), the output is the kept upper bits plus one exactly when the most significant discarded bit (bit `IN_W-OUT_W-1`) is one, and the kept bits otherwise.
- R3: With `MODE = RND_HALF_AWAY` (code 2), the output is the nearest value. An input exactly halfway between two outputs goes to the one of larger magnitude: up for positive inputs, down for negative inputs.
- R4: With `MODE = RND_HALF_EVEN` (code 3), the output is the nearest value. An input exactly halfway goes to the output whose bit 0 is zero.
- R5: The output word and `o_sync` change exactly one clock edge after the inputs are sampled with `i_ce` high, and `o_sync` equals the `i_sync` sampled at that edge.
- R6: While `i_ce` is low, `o_word` and `o_sync` hold their values, whatever happens on `i_word` and `i_sync`.
- R7: `i_rst` high at a clock edge clears `o_word` to zero and `o_sync` to 0 at that edge, regardless of `i_ce`.
- R8: When `IN_W = OUT_W + 1`, an input counts as halfway exactly when the single discarded bit is one, and the rules of R2 to R4 apply unchanged.
- R9: Elaboration fails unless 1 <= `OUT_W` < `IN_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous reset, active high |
| i_ce | input | 1 | Clock enable for both pipeline registers |
| i_word | input | IN_W | Signed wide input sample |
| i_sync | input | 1 | Sync/valid flag accompanying `i_word` |
| o_word | output | OUT_W | Rounded signed output sample |
| o_sync | output | 1 | `i_sync` delayed to align with `o_word` |

## Verification
The bench builds four instances with `IN_W = 10` and `OUT_W = 6`, one for each policy. All four are driven with the same samples, so a single vector table compares the four policies side by side. Four discarded bits leave room for values below, exactly at and above the halfway point, for both signs. A fifth instance with `IN_W = 7`, `OUT_W = 6` and the convergent policy reaches the one-bit-discard case, where there are no lower discarded bits to test.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
   typedef enum logic [1:0] {
      RND_TRUNC     = 2'd0,
      RND_HALF_UP   = 2'd1,
      RND_HALF_AWAY = 2'd2,
      RND_HALF_EVEN = 2'd3
   } rnd_mode_e;
endpackage

// File: rtl/fxr_split.sv
module fxr_split #(
   parameter int IN_W  = 10,
   parameter int OUT_W = 6,
   localparam int DROP = IN_W - OUT_W
) (
   input  logic [IN_W-1:0]  word,
   output logic [OUT_W-1:0] kept,
   output logic             guard,
   output logic             sticky
);
   assign kept  = word[IN_W-1:DROP];
   assign guard = word[DROP-1];
   generate
      if (DROP > 1) begin : g_tail
         assign sticky = |word[DROP-2:0];
      end else begin : g_notail
         assign sticky = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fxr_incr.sv
module fxr_incr #(
   parameter fxr_pkg::rnd_mode_e MODE = fxr_pkg::RND_HALF_EVEN
) (
   input  logic sign,
   input  logic kept_lsb,
   input  logic guard,
   input  logic sticky,
   output logic bump
);
   generate
      if (MODE == fxr_pkg::RND_TRUNC) begin : g_trunc
         logic unused_ins;
         assign unused_ins = ^{sign, kept_lsb, guard, sticky};
         assign bump = 1'b0;
      end else if (MODE == fxr_pkg::RND_HALF_UP) begin : g_up
         logic unused_ins;
         assign unused_ins = ^{sign, kept_lsb, sticky};
         assign bump = guard;
      end else if (MODE == fxr_pkg::RND_HALF_AWAY) begin : g_away
         logic unused_ins;
         assign unused_ins = kept_lsb;
         assign bump = guard & (sticky | ~sign);
      end else begin : g_even
         logic unused_ins;
         assign unused_ins = sign;
         assign bump = guard & (sticky | kept_lsb);
      end
   endgenerate
endmodule

// File: rtl/fxr_pipe_reg.sv
module fxr_pipe_reg #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d_word,
   input  logic         d_flag,
   output logic [W-1:0] q_word,
   output logic         q_flag
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_word <= '0;
         q_flag <= 1'b0;
      end else if (ce) begin
         q_word <= d_word;
         q_flag <= d_flag;
      end
   end
endmodule

// File: rtl/fxp_round_stage.sv
module fxp_round_stage #(
   parameter int IN_W  = 10,
   parameter int OUT_W = 6,
   parameter fxr_pkg::rnd_mode_e MODE = fxr_pkg::RND_HALF_EVEN
) (
   input  logic             i_clk,
   input  logic             i_rst,
   input  logic             i_ce,
   input  logic [IN_W-1:0]  i_word,
   input  logic             i_sync,
   output logic [OUT_W-1:0] o_word,
   output logic             o_sync
);
   // R9: parameter legality
   generate
      if (OUT_W < 1 || OUT_W >= IN_W) begin : g_bad_widths
         $error("fxp_round_stage: need 1 <= OUT_W < IN_W");
      end
   endgenerate

   logic [OUT_W-1:0] kept;
   logic             guard, sticky, bump;
   logic [OUT_W-1:0] rounded;

   fxr_split #(.IN_W(IN_W), .OUT_W(OUT_W)) u_split (
      .word(i_word), .kept(kept), .guard(guard), .sticky(sticky)
   );

   fxr_incr #(.MODE(MODE)) u_incr (
      .sign(i_word[IN_W-1]), .kept_lsb(kept[0]),
      .guard(guard), .sticky(sticky), .bump(bump)
   );

   assign rounded = kept + {{(OUT_W-1){1'b0}}, bump};

   fxr_pipe_reg #(.W(OUT_W)) u_reg (
      .clk(i_clk), .rst(i_rst), .ce(i_ce),
      .d_word(rounded), .d_flag(i_sync),
      .q_word(o_word), .q_flag(o_sync)
   );
endmodule

// File: rtl/fxr_round_chk.sv
module fxr_round_chk #(
   parameter int IN_W  = 10,
   parameter int OUT_W = 6,
   parameter fxr_pkg::rnd_mode_e MODE = fxr_pkg::RND_HALF_EVEN,
   localparam int DROP = IN_W - OUT_W
) (
   input logic             i_clk,
   input logic             i_rst,
   input logic             i_ce,
   input logic [IN_W-1:0]  i_word,
   input logic             i_sync,
   input logic [OUT_W-1:0] o_word,
   input logic             o_sync
);
   logic             started = 1'b0;
   logic [OUT_W-1:0] c_kept, c_kept1;
   logic             c_top, c_half;

   always_ff @(posedge i_clk) if (i_rst) started <= 1'b1;

   assign c_kept  = i_word[IN_W-1:DROP];
   assign c_kept1 = c_kept + 1'b1;
   assign c_top   = i_word[DROP-1];
   assign c_half  = c_top && ((i_word & ((IN_W'(1) << (DROP-1)) - IN_W'(1))) == '0);

   p_sync_lat_r5: assert property (@(posedge i_clk) disable iff (i_rst || !started)
      i_ce |=> (o_sync == $past(i_sync)));
   p_hold_r6: assert property (@(posedge i_clk) disable iff (i_rst || !started)
      !i_ce |=> ($stable(o_word) && $stable(o_sync)));
   p_reset_r7: assert property (@(posedge i_clk)
      i_rst |=> (o_word == '0 && !o_sync));
   p_near_kept_r5: assert property (@(posedge i_clk) disable iff (i_rst || !started)
      i_ce |=> (o_word == $past(c_kept) || o_word == $past(c_kept1)));

   generate
      if (MODE == fxr_pkg::RND_TRUNC) begin : g_a_trunc
         p_trunc_r1: assert property (@(posedge i_clk) disable iff (i_rst || !started)
            i_ce |=> (o_word == $past(c_kept)));
      end else if (MODE == fxr_pkg::RND_HALF_UP) begin : g_a_up
         p_half_up_r2: assert property (@(posedge i_clk) disable iff (i_rst || !started)
            i_ce |=> (o_word == ($past(c_top) ? $past(c_kept1) : $past(c_kept))));
      end else if (MODE == fxr_pkg::RND_HALF_AWAY) begin : g_a_away
         p_away_r3: assert property (@(posedge i_clk) disable iff (i_rst || !started)
            (i_ce && c_half) |=> (o_word == ($past(i_word[IN_W-1]) ? $past(c_kept) : $past(c_kept1))));
      end else begin : g_a_even
         p_even_r4: assert property (@(posedge i_clk) disable iff (i_rst || !started)
            (i_ce && c_half) |=> (o_word[0] == 1'b0));
      end
   endgenerate
endmodule

bind fxp_round_stage fxr_round_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .MODE(MODE)) u_chk (
   .i_clk(i_clk), .i_rst(i_rst), .i_ce(i_ce), .i_word(i_word),
   .i_sync(i_sync), .o_word(o_word), .o_sync(o_sync)
);

// File: tb/sim_fxp_round_stage.sv
module sim_fxp_round_stage;
   import fxr_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst = 1'b1, ce = 1'b0, sync = 1'b0;
   logic [9:0] w = '0;
   logic [6:0] w7 = '0;
   logic [5:0] o0, o1, o2, o3, o4;
   logic       s0, s1, s2, s3, s4;

   fxp_round_stage #(.IN_W(10), .OUT_W(6), .MODE(RND_TRUNC)) u0 (
      .i_clk(clk), .i_rst(rst), .i_ce(ce), .i_word(w), .i_sync(sync), .o_word(o0), .o_sync(s0));
   fxp_round_stage #(.IN_W(10), .OUT_W(6), .MODE(RND_HALF_UP)) u1 (
      .i_clk(clk), .i_rst(rst), .i_ce(ce), .i_word(w), .i_sync(sync), .o_word(o1), .o_sync(s1));
   fxp_round_stage #(.IN_W(10), .OUT_W(6), .MODE(RND_HALF_AWAY)) u2 (
      .i_clk(clk), .i_rst(rst), .i_ce(ce), .i_word(w), .i_sync(sync), .o_word(o2), .o_sync(s2));
   fxp_round_stage #(.IN_W(10), .OUT_W(6), .MODE(RND_HALF_EVEN)) u3 (
      .i_clk(clk), .i_rst(rst), .i_ce(ce), .i_word(w), .i_sync(sync), .o_word(o3), .o_sync(s3));
   fxp_round_stage #(.IN_W(7), .OUT_W(6), .MODE(RND_HALF_EVEN)) u4 (
      .i_clk(clk), .i_rst(rst), .i_ce(ce), .i_word(w7), .i_sync(sync), .o_word(o4), .o_sync(s4));

   // input (units of 1/16), then expected trunc, half-up, away, even
   localparam int TV [10][5] = '{
      '{ 40,  2,  3,  3,  2},
      '{ 56,  3,  4,  4,  4},
      '{-40, -3, -2, -3, -2},
      '{-56, -4, -3, -4, -4},
      '{ 41,  2,  3,  3,  3},
      '{ 39,  2,  2,  2,  2},
      '{-41, -3, -3, -3, -3},
      '{-39, -3, -2, -2, -2},
      '{  8,  0,  1,  1,  0},
      '{ -8, -1,  0, -1,  0}
   };

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      w = 10'd37;
      step(); step();
      chk("R7 reset word", int'(o3), 0);
      chk("R7 reset sync", int'(s3), 0);
      rst = 1'b0;
      ce  = 1'b1;

      // table: R1 trunc, R2 half-up, R3 away, R4 even
      for (int i = 0; i < 10; i++) begin
         w = 10'(TV[i][0]);
         step();
         chk("R1 trunc",     int'($signed(o0)), TV[i][1]);
         chk("R2 half-up",   int'($signed(o1)), TV[i][2]);
         chk("R3 half-away", int'($signed(o2)), TV[i][3]);
         chk("R4 half-even", int'($signed(o3)), TV[i][4]);
      end

      // R5 latency: new input not visible before the edge, visible after
      w = 10'(24);     // 1.5 -> even gives 2
      sync = 1'b1;
      #1;
      chk("R5 before edge word", int'($signed(o3)), TV[9][4]);
      chk("R5 before edge sync", int'(s3), 0);
      step();
      chk("R5 after edge word", int'($signed(o3)), 2);
      chk("R5 after edge sync", int'(s0), 1);
      sync = 1'b0;
      step();
      chk("R5 sync drops", int'(s2), 0);

      // R6: stall
      ce = 1'b0;
      w = 10'(100);
      sync = 1'b1;
      step(); step();
      chk("R6 hold word", int'($signed(o3)), 2);
      chk("R6 hold sync", int'(s3), 0);
      ce = 1'b1;
      step();
      chk("R6 resume word", int'($signed(o1)), 6);
      chk("R6 resume sync", int'(s1), 1);

      // R8: one discarded bit, units of 1/2
      w7 = 7'(5);
      step();
      chk("R8 +2.5 even", int'($signed(o4)), 2);
      w7 = 7'(7);
      step();
      chk("R8 +3.5 even", int'($signed(o4)), 4);
      w7 = 7'(-5);
      step();
      chk("R8 -2.5 even", int'($signed(o4)), -2);
      w7 = 7'(-4);
      step();
      chk("R8 -2.0 exact", int'($signed(o4)), -2);

      // R7: reset while ce low
      ce = 1'b0;
      rst = 1'b1;
      step();
      chk("R7 mid reset word", int'(o1), 0);
      chk("R7 mid reset sync", int'(s1), 0);
      rst = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule